// File: doc/BRIEF.md
# DRAM Refresh Address Generator

This block sits next to a processor core and generates the row addresses that keep dynamic RAM alive. An 8-bit refresh register steps forward by one each time the core finishes fetching an opcode. Only its lower seven bits take part in the count. The top bit is changed only when software writes the register, so it can hold one bit of stored state across any number of fetches.

A second 8-bit register holds an interrupt page value. The core's timing logic marks the refresh slot of each instruction, which falls while the fetched opcode is being decoded and executed. During that slot the block drives the two registers onto the address bus as one 16-bit word: the page register forms the upper byte and the refresh register forms the lower byte. It also asserts an active-low refresh strobe and the memory bus select.

Outside the slot, the normal core address passes through to the bus. Both registers can be loaded from a data byte. Either register can be read back through a one-byte read port. All outputs are registered, so each one reflects the inputs and register state of the cycle before.

Top module: `refresh_addr_gen`

## Requirements
- R1: A cycle with `rst` high clears both registers to 0x00. In the next cycle `rfsh_n` and `bus_sel_n` are 1 and `addr_out` is 0x0000.
- R2: A clock with `fetch_done` high and `ld_rfsh` low adds one to bits 6:0 of the refresh register.
- R3: Bit 7 of the refresh register is changed by no increment. It keeps the value from the last load.
- R4: When bits 6:0 are 0x7F, an increment sets them to 0x00 and does not carry into bit 7.
- R5: With `ld_rfsh` high, all 8 bits of `wr_data` are written into the refresh register. If `fetch_done` is high in the same clock, the load wins and no increment happens.
- R6: With `ld_page` high, `wr_data` is written into the page register. The refresh register is not affected.
- R7: One cycle after a clock, `rd_data` shows the refresh register if `rd_sel` was 0, or the page register if `rd_sel` was 1, as they stood before that clock.
- R8: If `rfsh_slot` is high at a clock, then after that clock `addr_out[15:8]` is the page register, `addr_out[7:0]` is the refresh register (both values from before the clock), and `rfsh_n` is 0.
- R9: If `rfsh_slot` is low at a clock, then after that clock `addr_out` equals the `cpu_addr` sampled at that clock and `rfsh_n` is 1.
- R10: `bus_sel_n` is 0 in the cycle after a clock at which `rfsh_slot` or `cpu_mreq` was high, and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_done | input | 1 | Pulse marking a completed opcode fetch |
| rfsh_slot | input | 1 | High during the refresh slot of the instruction cycle |
| cpu_addr | input | 16 | Normal core address |
| cpu_mreq | input | 1 | Core memory request, active high |
| ld_rfsh | input | 1 | Load the refresh register from wr_data |
| ld_page | input | 1 | Load the page register from wr_data |
| wr_data | input | 8 | Load data |
| rd_sel | input | 1 | Read select: 0 selects the refresh register, 1 selects the page register |
| rd_data | output | 8 | Registered read data |
| addr_out | output | 16 | Registered address bus |
| rfsh_n | output | 1 | Refresh strobe, active low |
| bus_sel_n | output | 1 | Memory bus select, active low |

## Verification
An explicit load of the refresh register and an opcode-fetch increment can fall in the same clock. The bench provokes this by pulsing `ld_rfsh` and `fetch_done` together. It uses load values that an increment would visibly change, including 0x7F and 0xFF. It then reads the register back and expects exactly the loaded byte. A refresh slot that coincides with a fetch increment is also driven. In that case the address low byte must carry the value from before the increment, and a later read must show the incremented value.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  localparam int RFSH_W = 8;
  localparam int PAGE_W = 8;

  typedef enum logic {
    RD_RFSH = 1'b0,
    RD_PAGE = 1'b1
  } rd_src_e;
endpackage

// File: rtl/rfsh_counter.sv
module rfsh_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         ld,
  input  logic [W-1:0] wd,
  output logic [W-1:0] q
);
  localparam int LW = W - 1;

  logic [LW-1:0] low_q;
  logic          top_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_q <= '0;
      top_q <= 1'b0;
    end else if (ld) begin
      low_q <= wd[LW-1:0];
      top_q <= wd[W-1];
    end else if (inc) begin
      low_q <= low_q + LW'(1);
    end
  end

  assign q = {top_q, low_q};

  // R1
  rfsh_reset_chk: assert property (@(posedge clk) rst |=> q == '0);
  // R2
  rfsh_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (inc && !ld) |=> low_q == LW'($past(low_q) + LW'(1)));
  // R3
  rfsh_top_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ld |=> $stable(top_q));
  // R4
  rfsh_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (inc && !ld && low_q == '1) |=> low_q == '0);
  // R5
  rfsh_load_chk: assert property (@(posedge clk) disable iff (rst)
    ld |=> q == $past(wd));
endmodule

// File: rtl/rfsh_page_reg.sv
module rfsh_page_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] wd,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (ld) q <= wd;
  end

  // R6
  page_load_chk: assert property (@(posedge clk) disable iff (rst)
    ld |=> q == $past(wd));
  // R6
  page_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ld |=> $stable(q));
endmodule

// File: rtl/rfsh_bus_out.sv
module rfsh_bus_out #(
  parameter int RW = 8,
  parameter int PW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            slot,
  input  logic            mreq,
  input  logic [RW+PW-1:0] cpu_addr,
  input  logic [RW-1:0]   rfsh_val,
  input  logic [PW-1:0]   page_val,
  output logic [RW+PW-1:0] addr_out,
  output logic            rfsh_n,
  output logic            bus_sel_n
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_out  <= '0;
      rfsh_n    <= 1'b1;
      bus_sel_n <= 1'b1;
    end else begin
      addr_out  <= slot ? {page_val, rfsh_val} : cpu_addr;
      rfsh_n    <= ~slot;
      bus_sel_n <= ~(slot | mreq);
    end
  end

  // R8
  slot_addr_chk: assert property (@(posedge clk) disable iff (rst)
    slot |=> (!rfsh_n && addr_out[RW-1:0] == $past(rfsh_val)
              && addr_out[RW+PW-1:RW] == $past(page_val)));
  // R9
  pass_addr_chk: assert property (@(posedge clk) disable iff (rst)
    !slot |=> (rfsh_n && addr_out == $past(cpu_addr)));
  // R10
  bus_sel_chk: assert property (@(posedge clk) disable iff (rst)
    (slot || mreq) |=> !bus_sel_n);
endmodule

// File: rtl/refresh_addr_gen.sv
module refresh_addr_gen #(
  parameter int RFSH_W = rfsh_pkg::RFSH_W,
  parameter int PAGE_W = rfsh_pkg::PAGE_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     fetch_done,
  input  logic                     rfsh_slot,
  input  logic [RFSH_W+PAGE_W-1:0] cpu_addr,
  input  logic                     cpu_mreq,
  input  logic                     ld_rfsh,
  input  logic                     ld_page,
  input  logic [RFSH_W-1:0]        wr_data,
  input  logic                     rd_sel,
  output logic [RFSH_W-1:0]        rd_data,
  output logic [RFSH_W+PAGE_W-1:0] addr_out,
  output logic                     rfsh_n,
  output logic                     bus_sel_n
);
  import rfsh_pkg::*;

  logic [RFSH_W-1:0] rfsh_q;
  logic [PAGE_W-1:0] page_q;

  rfsh_counter #(.W(RFSH_W)) u_cnt (
    .clk(clk), .rst(rst), .inc(fetch_done), .ld(ld_rfsh),
    .wd(wr_data), .q(rfsh_q)
  );

  rfsh_page_reg #(.W(PAGE_W)) u_page (
    .clk(clk), .rst(rst), .ld(ld_page),
    .wd(wr_data[PAGE_W-1:0]), .q(page_q)
  );

  rfsh_bus_out #(.RW(RFSH_W), .PW(PAGE_W)) u_bus (
    .clk(clk), .rst(rst), .slot(rfsh_slot), .mreq(cpu_mreq),
    .cpu_addr(cpu_addr), .rfsh_val(rfsh_q), .page_val(page_q),
    .addr_out(addr_out), .rfsh_n(rfsh_n), .bus_sel_n(bus_sel_n)
  );

  always_ff @(posedge clk) begin
    if (rst)                  rd_data <= '0;
    else if (rd_sel == RD_PAGE) rd_data <= RFSH_W'(page_q);
    else                      rd_data <= rfsh_q;
  end

  // R7
  rd_path_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_sel |=> rd_data == $past(rfsh_q));
endmodule

// File: tb/sim_refresh_addr_gen.sv
module sim_refresh_addr_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst, fetch_done, rfsh_slot, cpu_mreq, ld_rfsh, ld_page, rd_sel;
  logic [15:0] cpu_addr;
  logic [7:0]  wr_data, rd_data;
  logic [15:0] addr_out;
  logic        rfsh_n, bus_sel_n;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] m_rfsh, m_page;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  refresh_addr_gen u0 (
    .clk(clk), .rst(rst), .fetch_done(fetch_done), .rfsh_slot(rfsh_slot),
    .cpu_addr(cpu_addr), .cpu_mreq(cpu_mreq), .ld_rfsh(ld_rfsh),
    .ld_page(ld_page), .wr_data(wr_data), .rd_sel(rd_sel),
    .rd_data(rd_data), .addr_out(addr_out), .rfsh_n(rfsh_n),
    .bus_sel_n(bus_sel_n)
  );

  task automatic cmp(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One clock: drive at negedge, predict from the model, compare after the edge.
  task automatic step(bit fe, bit sl, bit lr, bit lp, logic [7:0] wd,
                      bit rs, logic [15:0] ca, bit mq, string tag);
    logic [15:0] e_addr;
    logic [7:0]  e_rd;
    @(negedge clk);
    fetch_done = fe; rfsh_slot = sl; ld_rfsh = lr; ld_page = lp;
    wr_data = wd; rd_sel = rs; cpu_addr = ca; cpu_mreq = mq;
    @(posedge clk);
    e_addr = sl ? {m_page, m_rfsh} : ca;
    e_rd   = rs ? m_page : m_rfsh;
    if (lr)      m_rfsh = wd;
    else if (fe) m_rfsh = {m_rfsh[7], m_rfsh[6:0] + 7'd1};
    if (lp)      m_page = wd;
    #1;
    cmp({tag, " addr (R8/R9)"}, addr_out, e_addr);
    cmp({tag, " rfsh_n (R8/R9)"}, {15'd0, rfsh_n}, {15'd0, ~sl});
    cmp({tag, " bus_sel_n (R10)"}, {15'd0, bus_sel_n}, {15'd0, ~(sl | mq)});
    cmp({tag, " rd_data (R7)"}, {8'd0, rd_data}, {8'd0, e_rd});
  endtask

  task automatic idle(bit rs, string tag);
    step(0, 0, 0, 0, 8'h00, rs, 16'h1234, 0, tag);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1; fetch_done = 1; rfsh_slot = 1; cpu_mreq = 1; ld_rfsh = 0;
    ld_page = 0; wr_data = 0; rd_sel = 0; cpu_addr = 16'hFFFF;
    @(posedge clk); @(negedge clk); rst = 0; fetch_done = 0; rfsh_slot = 0; cpu_mreq = 0;
    m_rfsh = 0; m_page = 0;
    cmp("R1 addr after reset", addr_out, 16'h0000);
    cmp("R1 rfsh_n after reset", {15'd0, rfsh_n}, 16'd1);
    cmp("R1 bus_sel_n after reset", {15'd0, bus_sel_n}, 16'd1);
    idle(0, "R1 refresh reg");
    idle(1, "R1 page reg");
  endtask

  task automatic t_increment();
    for (int i = 0; i < 5; i++) step(1, 0, 0, 0, 8'h00, 0, 16'h0100 + 16'(i), 0, "R2 inc");
    idle(0, "R2 readback");
    cmp("R2 count after 5 fetches", {8'd0, m_rfsh}, 16'h0005);
  endtask

  task automatic t_wrap();
    step(0, 0, 1, 0, 8'hFE, 0, 16'h0, 0, "R5 load FE");
    step(1, 0, 0, 0, 8'h00, 0, 16'h0, 0, "R4 to FF");
    step(1, 0, 0, 0, 8'h00, 0, 16'h0, 0, "R4 wrap to 80");
    step(1, 0, 0, 0, 8'h00, 0, 16'h0, 0, "R4 to 81");
    idle(0, "R4 readback 81");
    step(0, 0, 1, 0, 8'h7F, 0, 16'h0, 0, "R5 load 7F");
    step(1, 0, 0, 0, 8'h00, 0, 16'h0, 0, "R4 wrap to 00");
    idle(0, "R4 readback 00");
  endtask

  task automatic t_bit7();
    step(0, 0, 1, 0, 8'h80, 0, 16'h0, 0, "R3 load 80");
    for (int i = 0; i < 130; i++) begin
      step(1, 0, 0, 0, 8'h00, 0, 16'h0, 0, "R3 run");
      cmp("R3 model bit7 held", {15'd0, m_rfsh[7]}, 16'd1);
    end
    idle(0, "R3 readback");
  endtask

  task automatic t_collision();
    step(1, 0, 1, 0, 8'h7F, 0, 16'h0, 0, "R5 load+fetch 7F");
    idle(0, "R5 readback 7F");
    step(1, 0, 1, 0, 8'hFF, 0, 16'h0, 0, "R5 load+fetch FF");
    idle(0, "R5 readback FF");
    step(1, 1, 0, 0, 8'h00, 0, 16'h0, 0, "R8 slot with fetch");
    idle(0, "R8 readback after slot fetch");
  endtask

  task automatic t_page_and_slot();
    step(0, 0, 0, 1, 8'hA5, 0, 16'h0, 0, "R6 load page A5");
    idle(1, "R6 page readback");
    idle(0, "R6 refresh unchanged");
    step(0, 0, 1, 0, 8'h3C, 0, 16'h0, 0, "R5 load 3C");
    step(0, 1, 0, 0, 8'h00, 0, 16'hBEEF, 0, "R8 slot addr");
    step(0, 0, 0, 0, 8'h00, 0, 16'hBEEF, 0, "R9 passthrough");
    step(0, 0, 0, 0, 8'h00, 1, 16'h4321, 1, "R10 mreq");
    step(0, 1, 0, 1, 8'h5A, 1, 16'h0000, 1, "R8 slot with page load");
    idle(1, "R6 readback 5A");
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_increment();
    t_wrap();
    t_bit7();
    t_collision();
    t_page_and_slot();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule